// File: doc/BRIEF.md
# NAND Prefetch and Write-Posting Engine Controller

This block runs byte-counted block transfers between a NAND device and a staging FIFO. It has two directions. In prefetch mode it issues device reads and pushes each returned access into the FIFO. In write-posting mode it pops data out of the FIFO and issues device writes. Software loads a configuration while the engine is idle and then sets the start bit. The configuration holds the direction, a 3-bit chip-select link, the enable, a byte threshold and a byte count. The engine then pulls the remaining count down to zero and stops by itself.

The device width flag picks the access size: one byte per access for an 8-bit device, or one halfword for a 16-bit device. Counts, thresholds and the FIFO level are always in bytes. The engine also produces one interrupt/DMA event each time the FIFO reaches the programmed threshold. While the engine is enabled, it steers host accesses that target the linked chip-select to the FIFO port and away from the device.

Top module: `nand_prefetch_ctrl`

## Requirements
- R1: A configuration write (`cfg_wr`) updates direction, chip-select, enable, threshold and count only while `busy` is 0. While `busy` is 1 the write is ignored: the `cur_*` outputs keep their values and the next start uses the previously stored count.
- R2: The chip-select link is a 3-bit field (`cur_cs`). Host steering compares it against `host_cs`.
- R3: In prefetch (`cfg_post`=0) every completed device access (`dev_req` and `dev_ack` high together) pulses `fifo_push` in that same cycle, and `fifo_pop` stays 0. In write-posting (`cfg_post`=1) the access pulses `fifo_pop`, `fifo_push` stays 0, and `dev_write` is 1.
- R4: With `dev16`=0 every access moves one byte (`dev_size16`=0). With `dev16`=1 every access moves two bytes (`dev_size16`=1), except that a lone final byte is moved as a one-byte access. A count of N therefore takes N accesses on an 8-bit device and ceil(N/2) on a 16-bit device.
- R5: An accepted start loads `remaining` with the stored count on the next clock edge. Each completed access lowers it by the bytes that access moved, taking effect on the next edge.
- R6: `busy` falls on the edge where `remaining` reaches zero, with no software action. A start with a count of zero does not set `busy`. A start while `busy` is 1 is ignored.
- R7: `host_to_fifo` is 1 exactly when `host_req` is 1, `cur_enable` is 1 and `host_cs` equals `cur_cs`. `host_to_dev` is 1 for every other host request. Both are 0 when there is no host request.
- R8: In prefetch, `dev_req` is raised only while the FIFO free space (FIFO_BYTES minus `fifo_level`) is at least the pending access size in bytes. In write-posting it is raised only while `fifo_level` is at least that size.
- R9: While busy, the threshold condition is `fifo_level` >= `cur_thresh` in prefetch, and free space >= `cur_thresh` in write-posting. `dma_req` is a single-cycle pulse, one clock after the condition becomes true. The condition must fall and rise again before the next pulse. No pulse occurs while idle.
- R10: After reset, `busy`, `remaining`, `dev_req`, `fifo_push`, `fifo_pop`, `dma_req` and all `cur_*` configuration outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_post | input | 1 | Direction: 0 prefetch, 1 write-posting |
| cfg_cs | input | CS_W | Chip-select to link |
| cfg_enable | input | 1 | Engine enable (host steering) |
| cfg_thresh | input | LVL_W | Threshold in bytes |
| cfg_count | input | CNT_W | Transfer count in bytes |
| start_req | input | 1 | Start pulse |
| dev16 | input | 1 | Device is 16 bits wide |
| fifo_level | input | LVL_W | Bytes held in the staging FIFO |
| dev_ack | input | 1 | Device access completes this cycle |
| host_req | input | 1 | Host access request |
| host_cs | input | CS_W | Chip-select of host access |
| dev_req | output | 1 | Device access request |
| dev_size16 | output | 1 | Current access is a halfword |
| dev_write | output | 1 | Device access is a write |
| fifo_push | output | 1 | Push one access into the FIFO |
| fifo_pop | output | 1 | Pop one access from the FIFO |
| busy | output | 1 | Start bit / engine running |
| remaining | output | CNT_W | Bytes still to transfer |
| dma_req | output | 1 | Threshold event pulse |
| host_to_fifo | output | 1 | Host access steered to FIFO |
| host_to_dev | output | 1 | Host access goes to device |
| cur_post | output | 1 | Stored direction |
| cur_cs | output | CS_W | Stored chip-select link |
| cur_enable | output | 1 | Stored enable |
| cur_thresh | output | LVL_W | Stored threshold |

## Verification
The bench sweeps every count from 0 to 9 across both device widths and both directions. An odd count on a 16-bit device is the sharpest case there. A design that always issued halfwords would move one byte too many, underflow `remaining` and never drop `busy`. Configuration writes issued mid-transfer must leave the stored fields untouched, or a running transfer would switch direction or chip-select under way. The FIFO level is held at one byte below and exactly at an access size, which catches a flow gate that ignores access width and over- or under-runs the FIFO by one byte. The threshold is crossed, held, dropped and crossed again in both directions. A level-sensitive or misplaced event would show repeated pulses, a missing second pulse, or a pulse while idle.

// File: rtl/npf_pkg.sv
// Package: shared types for the NAND prefetch/write-posting engine.
// Assumes: one direction bit selects the transfer direction.
package npf_pkg;
    typedef enum logic {
        NPF_PREFETCH = 1'b0,
        NPF_POST     = 1'b1
    } npf_mode_e;
endpackage

// File: rtl/npf_cfg_regs.sv
// Module: configuration holding registers with run lock.
// Captures the configuration on a write strobe only while the engine is idle.
// Assumes: busy comes from the sequencer and is the start bit.
module npf_cfg_regs
    import npf_pkg::*;
#(
    parameter int CS_W  = 3,
    parameter int LVL_W = 7,
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             wr,
    input  npf_mode_e        mode_in,
    input  logic [CS_W-1:0]  cs_in,
    input  logic             en_in,
    input  logic [LVL_W-1:0] thr_in,
    input  logic [CNT_W-1:0] cnt_in,
    output npf_mode_e        mode_q,
    output logic [CS_W-1:0]  cs_q,
    output logic             en_q,
    output logic [LVL_W-1:0] thr_q,
    output logic [CNT_W-1:0] cnt_q
);
    // Store configuration fields; writes during a run are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= NPF_PREFETCH;
            cs_q   <= '0;
            en_q   <= 1'b0;
            thr_q  <= '0;
            cnt_q  <= '0;
        end else if (wr && !busy) begin
            mode_q <= mode_in;
            cs_q   <= cs_in;
            en_q   <= en_in;
            thr_q  <= thr_in;
            cnt_q  <= cnt_in;
        end
    end
endmodule

// File: rtl/npf_xfer_seq.sv
// Module: transfer sequencer.
// Issues byte or halfword device accesses gated by FIFO room or data,
// keeps the byte countdown and clears the run state at zero.
// Assumes: fifo_level is in bytes; dev_ack completes the access in the cycle
// it is seen together with dev_req.
module npf_xfer_seq
    import npf_pkg::*;
#(
    parameter int CNT_W      = 14,
    parameter int FIFO_BYTES = 64,
    parameter int LVL_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [CNT_W-1:0] count_in,
    input  npf_mode_e        mode,
    input  logic             dev16,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             dev_ack,
    output logic             busy,
    output logic [CNT_W-1:0] remaining,
    output logic             dev_req,
    output logic             dev_size16,
    output logic             dev_write,
    output logic             fifo_push,
    output logic             fifo_pop
);
    logic [LVL_W:0]  held_b;
    logic [LVL_W:0]  free_b;
    logic [LVL_W:0]  avail_b;
    logic [LVL_W:0]  need_b;
    logic [CNT_W-1:0] step_c;
    logic            wide;
    logic            xfer;

    // Halfword only when the device is 16 bits and two or more bytes remain.
    assign wide   = dev16 && (remaining > CNT_W'(1));
    assign need_b = wide ? (LVL_W+1)'(2) : (LVL_W+1)'(1);
    assign step_c = wide ? CNT_W'(2) : CNT_W'(1);

    // Bytes available for the pending access in the active direction.
    assign held_b  = {1'b0, fifo_level};
    assign free_b  = (LVL_W+1)'(FIFO_BYTES) - held_b;
    assign avail_b = (mode == NPF_POST) ? held_b : free_b;

    assign dev_req    = busy && (avail_b >= need_b);
    assign dev_size16 = dev_req && wide;
    assign dev_write  = (mode == NPF_POST);
    assign xfer       = dev_req && dev_ack;
    assign fifo_push  = xfer && (mode == NPF_PREFETCH);
    assign fifo_pop   = xfer && (mode == NPF_POST);

    // Run state and byte countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            remaining <= '0;
        end else if (start_req && !busy) begin
            remaining <= count_in;
            busy      <= (count_in != '0);
        end else if (xfer) begin
            remaining <= remaining - step_c;
            if (remaining == step_c) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/npf_thresh_evt.sv
// Module: threshold event generator.
// Forms the threshold condition from FIFO level (prefetch) or free space
// (write-posting) and emits one pulse per rising crossing.
// Assumes: the condition is only meaningful while the engine runs.
module npf_thresh_evt
    import npf_pkg::*;
#(
    parameter int FIFO_BYTES = 64,
    parameter int LVL_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  npf_mode_e        mode,
    input  logic [LVL_W-1:0] thresh,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             dma_req
);
    logic [LVL_W:0] metric;
    logic           hit;
    logic           hit_q;

    assign metric = (mode == NPF_POST)
                  ? ((LVL_W+1)'(FIFO_BYTES) - {1'b0, fifo_level})
                  : {1'b0, fifo_level};
    assign hit    = busy && (metric >= {1'b0, thresh});

    // Remember the previous condition and pulse on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q   <= 1'b0;
            dma_req <= 1'b0;
        end else begin
            hit_q   <= hit;
            dma_req <= hit && !hit_q;
        end
    end
endmodule

// File: rtl/nand_prefetch_ctrl.sv
// Module: NAND prefetch / write-posting engine controller (top).
// Ties configuration, sequencer and threshold event together and steers
// host accesses of the linked chip-select to the FIFO while enabled.
// Assumes: FIFO storage and NAND pin timing live outside this block.
module nand_prefetch_ctrl
    import npf_pkg::*;
#(
    parameter int CS_W       = 3,
    parameter int CNT_W      = 14,
    parameter int FIFO_BYTES = 64,
    localparam int LVL_W     = $clog2(FIFO_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_post,
    input  logic [CS_W-1:0]  cfg_cs,
    input  logic             cfg_enable,
    input  logic [LVL_W-1:0] cfg_thresh,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             start_req,
    input  logic             dev16,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             dev_ack,
    input  logic             host_req,
    input  logic [CS_W-1:0]  host_cs,
    output logic             dev_req,
    output logic             dev_size16,
    output logic             dev_write,
    output logic             fifo_push,
    output logic             fifo_pop,
    output logic             busy,
    output logic [CNT_W-1:0] remaining,
    output logic             dma_req,
    output logic             host_to_fifo,
    output logic             host_to_dev,
    output logic             cur_post,
    output logic [CS_W-1:0]  cur_cs,
    output logic             cur_enable,
    output logic [LVL_W-1:0] cur_thresh
);
    npf_mode_e        mode_q;
    logic [CNT_W-1:0] count_q;

    npf_cfg_regs #(.CS_W(CS_W), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .wr      (cfg_wr),
        .mode_in (npf_mode_e'(cfg_post)),
        .cs_in   (cfg_cs),
        .en_in   (cfg_enable),
        .thr_in  (cfg_thresh),
        .cnt_in  (cfg_count),
        .mode_q  (mode_q),
        .cs_q    (cur_cs),
        .en_q    (cur_enable),
        .thr_q   (cur_thresh),
        .cnt_q   (count_q)
    );

    npf_xfer_seq #(.CNT_W(CNT_W), .FIFO_BYTES(FIFO_BYTES), .LVL_W(LVL_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .count_in   (count_q),
        .mode       (mode_q),
        .dev16      (dev16),
        .fifo_level (fifo_level),
        .dev_ack    (dev_ack),
        .busy       (busy),
        .remaining  (remaining),
        .dev_req    (dev_req),
        .dev_size16 (dev_size16),
        .dev_write  (dev_write),
        .fifo_push  (fifo_push),
        .fifo_pop   (fifo_pop)
    );

    npf_thresh_evt #(.FIFO_BYTES(FIFO_BYTES), .LVL_W(LVL_W)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .mode       (mode_q),
        .thresh     (cur_thresh),
        .fifo_level (fifo_level),
        .dma_req    (dma_req)
    );

    assign cur_post = (mode_q == NPF_POST);

    // Host steering: linked chip-select goes to the FIFO while enabled.
    assign host_to_fifo = host_req && cur_enable && (host_cs == cur_cs);
    assign host_to_dev  = host_req && !host_to_fifo;
endmodule

// File: rtl/npf_ctrl_chk.sv
// Module: property checker for nand_prefetch_ctrl, attached by bind.
// Assumes: observes top-level ports only.
module npf_ctrl_chk #(
    parameter int CS_W       = 3,
    parameter int CNT_W      = 14,
    parameter int FIFO_BYTES = 64,
    parameter int LVL_W      = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dev16,
    input logic [LVL_W-1:0] fifo_level,
    input logic             dev_ack,
    input logic             host_req,
    input logic [CS_W-1:0]  host_cs,
    input logic             dev_req,
    input logic             dev_size16,
    input logic             fifo_push,
    input logic             fifo_pop,
    input logic             busy,
    input logic [CNT_W-1:0] remaining,
    input logic             dma_req,
    input logic             host_to_fifo,
    input logic             host_to_dev,
    input logic             cur_post,
    input logic [CS_W-1:0]  cur_cs,
    input logic             cur_enable,
    input logic [LVL_W-1:0] cur_thresh
);
    p_cfg_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cur_cs) && $stable(cur_post) && $stable(cur_enable) && $stable(cur_thresh)));

    p_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (!cur_post && dev_req && dev_ack && !fifo_pop));

    p_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (cur_post && dev_req && dev_ack));

    p_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_size16 |-> (dev16 && dev_req && remaining > CNT_W'(1)));

    p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dev_req && dev_ack) |=>
            (remaining == $past(remaining) - ($past(dev_size16) ? CNT_W'(2) : CNT_W'(1))));

    p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (remaining == '0));

    p_steer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_to_fifo |-> (host_req && cur_enable && host_cs == cur_cs && !host_to_dev));

    p_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && !cur_post) |->
            (((LVL_W+1)'(FIFO_BYTES) - {1'b0, fifo_level}) >= (dev_size16 ? (LVL_W+1)'(2) : (LVL_W+1)'(1))));

    p_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && cur_post) |->
            ({1'b0, fifo_level} >= (dev_size16 ? (LVL_W+1)'(2) : (LVL_W+1)'(1))));

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !dma_req);
endmodule

bind nand_prefetch_ctrl npf_ctrl_chk #(
    .CS_W(CS_W), .CNT_W(CNT_W), .FIFO_BYTES(FIFO_BYTES), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dev16(dev16), .fifo_level(fifo_level),
    .dev_ack(dev_ack), .host_req(host_req), .host_cs(host_cs),
    .dev_req(dev_req), .dev_size16(dev_size16), .fifo_push(fifo_push),
    .fifo_pop(fifo_pop), .busy(busy), .remaining(remaining),
    .dma_req(dma_req), .host_to_fifo(host_to_fifo), .host_to_dev(host_to_dev),
    .cur_post(cur_post), .cur_cs(cur_cs), .cur_enable(cur_enable),
    .cur_thresh(cur_thresh)
);

// File: tb/tb_nand_prefetch_ctrl.sv
`timescale 1ns/1ps
module tb_nand_prefetch_ctrl;
    localparam int CS_W = 3;
    localparam int CNT_W = 14;
    localparam int FB = 64;
    localparam int LVL_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, cfg_post = 1'b0, cfg_enable = 1'b0;
    logic [CS_W-1:0] cfg_cs = '0;
    logic [LVL_W-1:0] cfg_thresh = '0;
    logic [CNT_W-1:0] cfg_count = '0;
    logic start_req = 1'b0, dev16 = 1'b0, dev_ack = 1'b0, host_req = 1'b0;
    logic [LVL_W-1:0] fifo_level = '0;
    logic [CS_W-1:0] host_cs = '0;
    logic dev_req, dev_size16, dev_write, fifo_push, fifo_pop, busy, dma_req;
    logic host_to_fifo, host_to_dev, cur_post, cur_enable;
    logic [CNT_W-1:0] remaining;
    logic [CS_W-1:0] cur_cs;
    logic [LVL_W-1:0] cur_thresh;

    int n_chk = 0;
    int n_err = 0;

    nand_prefetch_ctrl #(.CS_W(CS_W), .CNT_W(CNT_W), .FIFO_BYTES(FB)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_post(cfg_post),
        .cfg_cs(cfg_cs), .cfg_enable(cfg_enable), .cfg_thresh(cfg_thresh),
        .cfg_count(cfg_count), .start_req(start_req), .dev16(dev16),
        .fifo_level(fifo_level), .dev_ack(dev_ack), .host_req(host_req),
        .host_cs(host_cs), .dev_req(dev_req), .dev_size16(dev_size16),
        .dev_write(dev_write), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
        .busy(busy), .remaining(remaining), .dma_req(dma_req),
        .host_to_fifo(host_to_fifo), .host_to_dev(host_to_dev),
        .cur_post(cur_post), .cur_cs(cur_cs), .cur_enable(cur_enable),
        .cur_thresh(cur_thresh)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic configure(input bit post, input int cs, input bit en, input int thr, input int cnt);
        @(negedge clk);
        cfg_post = post; cfg_cs = CS_W'(cs); cfg_enable = en;
        cfg_thresh = LVL_W'(thr); cfg_count = CNT_W'(cnt); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic start();
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic finish_run();
        dev_ack = 1'b1;
        fifo_level = cur_post ? LVL_W'(FB) : '0;
        while (busy) @(negedge clk);
        dev_ack = 1'b0;
    endtask

    task automatic run_xfer(input int cnt, input bit d16, input bit post);
        int rem = cnt;
        int acc = 0;
        int guard = 0;
        dev16 = d16;
        dev_ack = 1'b1;
        fifo_level = post ? LVL_W'(FB) : '0;
        configure(post, 5, 1'b1, 40, cnt);
        start();
        chk(busy == (cnt != 0), "R6 busy after start", busy, cnt != 0);
        while (busy && guard < 40) begin
            #1;
            chk(remaining == CNT_W'(rem), "R5 remaining", remaining, rem);
            chk(dev_req == 1'b1, "R8 request with room", dev_req, 1);
            if (dev_req) begin
                int st = (d16 && rem >= 2) ? 2 : 1;
                chk(dev_size16 == (st == 2), "R4 access size", dev_size16, st == 2);
                chk(fifo_push == !post && fifo_pop == post, "R3 fifo strobe",
                    {fifo_push, fifo_pop}, post ? 1 : 2);
                chk(dev_write == post, "R3 direction", dev_write, post);
                rem -= st;
                acc++;
            end
            @(negedge clk);
            guard++;
        end
        chk(busy == 1'b0, "R6 busy cleared", busy, 0);
        chk(remaining == '0, "R6 remaining zero", remaining, 0);
        chk(acc == (d16 ? (cnt + 1) / 2 : cnt), "R4 access count", acc, d16 ? (cnt + 1) / 2 : cnt);
        dev_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(busy == 0 && remaining == 0, "R10 reset busy/remaining", {busy, remaining}, 0);
        chk(dev_req == 0 && fifo_push == 0 && fifo_pop == 0 && dma_req == 0,
            "R10 reset strobes", {dev_req, fifo_push, fifo_pop, dma_req}, 0);
        chk(cur_cs == 0 && cur_post == 0 && cur_enable == 0 && cur_thresh == 0,
            "R10 reset config", {cur_cs, cur_post, cur_enable, cur_thresh}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 R4 R5 R6: sweep counts, widths and directions.
        for (int p = 0; p < 2; p++)
            for (int w = 0; w < 2; w++)
                for (int c = 0; c < 10; c++)
                    run_xfer(c, w[0], p[0]);

        // R1 lock and R8 prefetch gating.
        dev_ack = 1'b0; dev16 = 1'b0; fifo_level = '0;
        configure(1'b0, 2, 1'b1, 30, 6);
        start();
        configure(1'b1, 6, 1'b0, 5, 3);
        #1;
        chk(cur_cs == 2, "R1 cs locked", cur_cs, 2);
        chk(cur_post == 0, "R1 mode locked", cur_post, 0);
        chk(cur_enable == 1, "R1 enable locked", cur_enable, 1);
        chk(cur_thresh == 30, "R1 threshold locked", cur_thresh, 30);
        fifo_level = LVL_W'(FB); #1;
        chk(dev_req == 0, "R8 prefetch full", dev_req, 0);
        fifo_level = LVL_W'(FB - 1); #1;
        chk(dev_req == 1, "R8 prefetch one byte free", dev_req, 1);
        dev16 = 1'b1; #1;
        chk(dev_req == 0, "R8 prefetch halfword needs two", dev_req, 0);
        fifo_level = LVL_W'(FB - 2); #1;
        chk(dev_req == 1, "R8 prefetch two free", dev_req, 1);
        start();
        #1;
        chk(remaining == 6, "R6 start ignored while busy", remaining, 6);
        finish_run();
        start();
        #1;
        chk(remaining == 6, "R1 count kept after ignored write", remaining, 6);
        finish_run();

        // R8 write-posting gating.
        configure(1'b1, 1, 1'b1, 30, 5);
        dev16 = 1'b1; fifo_level = '0;
        start();
        fifo_level = 7'd1; #1;
        chk(dev_req == 0, "R8 post one byte for halfword", dev_req, 0);
        fifo_level = 7'd2; #1;
        chk(dev_req == 1, "R8 post two bytes", dev_req, 1);
        dev16 = 1'b0; fifo_level = 7'd1; #1;
        chk(dev_req == 1, "R8 post byte device", dev_req, 1);
        fifo_level = 7'd0; #1;
        chk(dev_req == 0, "R8 post empty", dev_req, 0);
        finish_run();

        // R2 R7: host steering sweep.
        for (int e = 0; e < 2; e++) begin
            configure(1'b0, 3, e[0], 0, 0);
            for (int c = 0; c < 8; c++) begin
                host_req = 1'b1; host_cs = CS_W'(c); #1;
                chk(host_to_fifo == (e == 1 && c == 3), "R7 steer fifo", host_to_fifo, e == 1 && c == 3);
                chk(host_to_dev == !(e == 1 && c == 3), "R2 steer device", host_to_dev, !(e == 1 && c == 3));
                @(negedge clk);
            end
        end
        host_req = 1'b0; #1;
        chk(host_to_fifo == 0 && host_to_dev == 0, "R7 no request", {host_to_fifo, host_to_dev}, 0);

        // R9 prefetch threshold on level.
        fifo_level = '0; dev_ack = 1'b0; dev16 = 1'b0;
        configure(1'b0, 0, 1'b1, 10, 200);
        start();
        for (int lv = 0; lv <= 20; lv++) begin
            @(negedge clk);
            fifo_level = LVL_W'(lv);
            @(negedge clk);
            chk(dma_req == (lv == 10), "R9 prefetch crossing", dma_req, lv == 10);
        end
        @(negedge clk);
        fifo_level = 7'd3;
        @(negedge clk);
        chk(dma_req == 0, "R9 below threshold", dma_req, 0);
        fifo_level = 7'd15;
        @(negedge clk);
        chk(dma_req == 1, "R9 second crossing", dma_req, 1);
        @(negedge clk);
        chk(dma_req == 0, "R9 single pulse", dma_req, 0);
        finish_run();
        fifo_level = 7'd60;
        repeat (2) @(negedge clk);
        chk(dma_req == 0, "R9 idle no event", dma_req, 0);

        // R9 write-posting threshold on free space.
        fifo_level = LVL_W'(FB);
        configure(1'b1, 0, 1'b1, 8, 200);
        start();
        for (int lv = FB; lv >= 50; lv--) begin
            @(negedge clk);
            fifo_level = LVL_W'(lv);
            @(negedge clk);
            chk(dma_req == (lv == FB - 8), "R9 post crossing", dma_req, lv == FB - 8);
        end
        finish_run();

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule